// File: doc/BRIEF.md
# Bit-Serial Adder

This block adds two unsigned operands of `WIDTH` bits by walking through them one bit pair per clock, lowest bit first. A load strobe copies both parallel operands into two right-shifting registers. A start pulse then lets the low bits of those registers feed a one-bit adder state machine. The machine keeps the running carry as its state. A third shift register gathers the sum bits from the top end, so once the run ends the whole sum can be read in parallel, together with a flag that carries the final carry.

The adder machine comes in two forms, selected by the `MOORE` parameter. In the default form (`MOORE = 0`) the sum bit is formed combinationally from the two operand bits and the stored carry. The machine then has two states: carry clear and carry set. In the other form (`MOORE = 1`) the sum bit is registered next to the carry. This gives four states, encoded as {carry, sum}. Each sum bit therefore reaches the collector one clock later, and the run takes one extra clock. During that extra clock the carry is frozen and only the collector moves.

Top module: `serialAdder`

## Requirements
- R1: While reset is asserted (`rstN` low), and right after reset, `done` is 0, `sum` is all zeros and `carryOut` is 0.
- R2: A clock edge with `load` high captures `opA` and `opB`, clears `sum` to zero, clears the carry state and drops `done`. `load` takes priority over `start`.
- R3: With `MOORE = 0`, once `done` is high, `sum` equals `(opA + opB) mod 2^WIDTH`. The carry state sets only when both operand bits are 1, clears only when both are 0, and otherwise stays as it is.
- R4: With `MOORE = 0`, once `done` is high, `carryOut` equals bit `WIDTH` of `opA + opB`.
- R5: With `MOORE = 0`, `done` reads 0 for the first `WIDTH-1` clock edges after the edge that samples `start`, and reads 1 after the `WIDTH`-th edge.
- R6: With `MOORE = 1`, once `done` is high, `sum` and `carryOut` equal the low `WIDTH` bits and bit `WIDTH` of `opA + opB`.
- R7: With `MOORE = 1`, `done` reads 0 for the first `WIDTH` edges after the `start` edge, and reads 1 after the `WIDTH+1`-th edge.
- R8: While `done` is high and neither `load` nor `start` is asserted, `done`, `sum` and `carryOut` keep their values.
- R9: A `start` pulse that arrives while a run is in progress is ignored. The run ends at its original time with the correct result.
- R10: `carryOut` is 0 whenever `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Capture operands and clear the result |
| opA | input | WIDTH | First operand, parallel |
| opB | input | WIDTH | Second operand, parallel |
| start | input | 1 | Begin a serial addition when idle |
| done | output | 1 | The result is complete and held |
| sum | output | WIDTH | Parallel sum collected bit by bit |
| carryOut | output | 1 | Carry out of the top bit, valid with `done` |

## Verification
The bench runs every pair of 4-bit operands through both forms of the adder at once. This covers carries that ripple across the whole width (all ones plus one), additions that produce no carry at all (zero plus zero), and 15 plus 15, which keeps the carry set in every step.

A design that mishandles the carry state yields sums that are wrong only when a carry has to ripple. A collector that ignores the one-clock lag of the registered form yields a sum shifted by one place, with a stale bit at the top. The bench also checks the clock on which `done` rises against the expected run length, in both forms. A counter off by one would let the registered form lose its last bit, or let the combinational form shift once too often.

Repeat `start` pulses are sent in the middle of a run. The outputs are watched for several clocks after completion, to catch a run that restarts or a result that drifts.

// File: rtl/serAddPkg.sv
package serAddPkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadOps;   // capture operands, clear result and carry
    logic stepFsm;   // shift operands and advance the adder state
    logic collect;   // shift one bit into the sum collector
  } serAddCtl_t;

endpackage

// File: rtl/serAddCtrl.sv
module serAddCtrl
  import serAddPkg::*;
#(
  parameter int WIDTH = 8,
  parameter bit MOORE = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       load,
  input  logic       start,
  output serAddCtl_t ctl,
  output logic       busy,
  output logic       done
);

  // The registered form needs one extra clock to drain the sum flop
  localparam int RUNLEN = MOORE ? WIDTH + 1 : WIDTH;
  localparam int CW     = $clog2(RUNLEN + 1);
  localparam logic [CW-1:0] LAST   = CW'(RUNLEN - 1);
  localparam logic [CW-1:0] STEPS  = CW'(WIDTH);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      done <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    ctl.loadOps = load;
    ctl.stepFsm = busy && (cnt < STEPS);
    ctl.collect = busy;
  end

endmodule

// File: rtl/serAddDatapath.sv
module serAddDatapath
  import serAddPkg::*;
#(
  parameter int WIDTH = 8,
  parameter bit MOORE = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  serAddCtl_t       ctl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sumReg,
  output logic             aBit,
  output logic             bBit,
  output logic             carryQ
);

  logic [WIDTH-1:0] regA;
  logic [WIDTH-1:0] regB;
  logic             fullSum;
  logic             fullCarry;
  logic             colBit;

  assign aBit      = regA[0];
  assign bBit      = regB[0];
  assign fullSum   = aBit ^ bBit ^ carryQ;
  assign fullCarry = (aBit & bBit) | (aBit & carryQ) | (bBit & carryQ);

  // Operand shifters and the carry state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regA   <= '0;
      regB   <= '0;
      carryQ <= 1'b0;
    end else if (ctl.loadOps) begin
      regA   <= opA;
      regB   <= opB;
      carryQ <= 1'b0;
    end else if (ctl.stepFsm) begin
      regA   <= {1'b0, regA[WIDTH-1:1]};
      regB   <= {1'b0, regB[WIDTH-1:1]};
      carryQ <= fullCarry;
    end
  end

  // Sum bit source: combinational, or a registered flop ({carry,sum} state)
  generate
    if (MOORE) begin : g_moore
      logic sumQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              sumQ <= 1'b0;
        else if (ctl.loadOps)   sumQ <= 1'b0;
        else if (ctl.stepFsm)   sumQ <= fullSum;
      end
      assign colBit = sumQ;
    end else begin : g_mealy
      assign colBit = fullSum;
    end
  endgenerate

  // Collector fills from the top so the first bit lands at position 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              sumReg <= '0;
    else if (ctl.loadOps)   sumReg <= '0;
    else if (ctl.collect)   sumReg <= {colBit, sumReg[WIDTH-1:1]};
  end

endmodule

// File: rtl/serialAdder.sv
module serialAdder
  import serAddPkg::*;
#(
  parameter int WIDTH = 8,
  parameter bit MOORE = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             start,
  output logic             done,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut
);

  serAddCtl_t ctl;
  logic       busy;
  logic       aBit;
  logic       bBit;
  logic       carryQ;

  serAddCtrl #(.WIDTH(WIDTH), .MOORE(MOORE)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .load  (load),
    .start (start),
    .ctl   (ctl),
    .busy  (busy),
    .done  (done)
  );

  serAddDatapath #(.WIDTH(WIDTH), .MOORE(MOORE)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .opA    (opA),
    .opB    (opB),
    .sumReg (sum),
    .aBit   (aBit),
    .bBit   (bBit),
    .carryQ (carryQ)
  );

  assign carryOut = done & carryQ;

endmodule

// File: rtl/serialAdderChk.sv
module serialAdderChk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             load,
  input logic             start,
  input logic             done,
  input logic [WIDTH-1:0] sum,
  input logic             carryOut,
  input logic             busy,
  input logic             stepFsm,
  input logic             aBit,
  input logic             bBit,
  input logic             carryQ
);

  p_load_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    load |=> (!done && sum == '0 && !carryQ));

  p_carry_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stepFsm && !load && aBit && bBit) |=> carryQ);

  p_carry_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stepFsm && !load && !aBit && !bBit) |=> !carryQ);

  p_carry_keep_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stepFsm && !load && (aBit ^ bBit)) |=> $stable(carryQ));

  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !load && !start) |=> (done && $stable(sum) && $stable(carryOut)));

  p_run_not_aborted_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !load) |=> (busy || done));

  p_carry_needs_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(carryOut) |-> $rose(done));

endmodule

bind serialAdder serialAdderChk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .load     (load),
  .start    (start),
  .done     (done),
  .sum      (sum),
  .carryOut (carryOut),
  .busy     (busy),
  .stepFsm  (ctl.stepFsm),
  .aBit     (aBit),
  .bBit     (bBit),
  .carryQ   (carryQ)
);

// File: tb/serialAdder_tb.sv
module serialAdder_tb;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         load = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         doneM, doneR;
  logic [W-1:0] sumM, sumR;
  logic         coM, coR;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  serialAdder #(.WIDTH(W), .MOORE(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .load(load), .opA(opA), .opB(opB),
    .start(start), .done(doneM), .sum(sumM), .carryOut(coM)
  );

  serialAdder #(.WIDTH(W), .MOORE(1'b1)) u_dutMoore (
    .clk(clk), .rstN(rstN), .load(load), .opA(opA), .opB(opB),
    .start(start), .done(doneR), .sum(sumR), .carryOut(coR)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (A=%0d B=%0d) t=%0t", req, act, exp, opA, opB, $time);
    end
  endtask

  // One full addition on both forms; midStart pulses start during the run
  task automatic runAdd(input int a, input int b, input bit midStart, input bit holdCheck);
    int total = a + b;
    int expSum = total % (1 << W);
    int expCo  = total >> W;
    @(negedge clk);
    opA = W'(a); opB = W'(b); load = 1'b1; start = 1'b1;  // load wins over start
    @(negedge clk);
    load = 1'b0; start = 1'b0;
    check(doneM == 1'b0 && sumM == '0, "R2", int'(sumM), 0);
    check(doneR == 1'b0 && sumR == '0, "R2", int'(sumR), 0);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i <= W + 1; i++) begin
      if (midStart && i == 2) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(doneM == (i >= W), midStart ? "R9" : "R5", int'(doneM), int'(i >= W));
      check(doneR == (i >= W + 1), midStart ? "R9" : "R7", int'(doneR), int'(i >= W + 1));
      if (!doneM) check(coM == 1'b0, "R10", int'(coM), 0);
      if (!doneR) check(coR == 1'b0, "R10", int'(coR), 0);
    end
    check(int'(sumM) == expSum, "R3", int'(sumM), expSum);
    check(int'(coM) == expCo, "R4", int'(coM), expCo);
    check(int'(sumR) == expSum, "R6", int'(sumR), expSum);
    check(int'(coR) == expCo, "R6", int'(coR), expCo);
    if (holdCheck) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check(doneM && int'(sumM) == expSum && int'(coM) == expCo, "R8", int'(sumM), expSum);
        check(doneR && int'(sumR) == expSum && int'(coR) == expCo, "R8", int'(sumR), expSum);
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: outputs while held in reset
    check(doneM == 0 && sumM == '0 && coM == 0, "R1", int'(sumM), 0);
    check(doneR == 0 && sumR == '0 && coR == 0, "R1", int'(sumR), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(doneM == 0 && sumM == '0 && coM == 0, "R1", int'(doneM), 0);
    check(doneR == 0 && sumR == '0 && coR == 0, "R1", int'(doneR), 0);

    // Corner cases first: zeros, all ones, full ripple
    runAdd(0, 0, 1'b0, 1'b1);
    runAdd((1 << W) - 1, (1 << W) - 1, 1'b0, 1'b1);
    runAdd((1 << W) - 1, 1, 1'b0, 1'b1);
    runAdd(5, 10, 1'b1, 1'b1);

    // Exhaustive sweep
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        runAdd(a, b, ((a + b) % 7) == 0, (a == b));
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule